// File: doc/BRIEF.md
# Repair Spare Cell with Upstream Re-routing

This block is a standby cell in a fault-repair fabric. It sits beside four primary cells (left, down, right, top) and keeps a copy of the configuration word of each one. A repair controller outside the block decides when a primary cell has failed. It then loads an "express" flag and a two-bit neighbour selector into the spare. From then on the spare computes the function of the chosen neighbour, a one-bit full adder, using that neighbour's operands.

The carry input of the expressed function comes from upstream. The upstream producer may be the original upstream primary cell, or one of that cell's four spares if it has itself been repaired. Each neighbour position has its own selection multiplexer. It picks the upstream carry according to the stored configuration and the upstream repair status, which arrive as inputs. Only the multiplexer of the expressed neighbour is connected; the other three are held off. While the spare is not expressing, its results are forced to zero and its valid flag is low.

Top module: `spare_cell`

## Requirements
- R1: After reset the cell is not expressing: outValid, sum, carry and routeActive are all 0.
- R2: While not expressing, sum, carry and outValid stay 0 whatever values the operand and upstream inputs carry.
- R3: The express flag and the selector are registered and change only on a rising clock edge with cfgLoad high; changes on cfgDiff or cfgDir without cfgLoad leave outValid and routeActive unchanged.
- R4: The selector code names the expressed neighbour: 0 left, 1 down, 2 right, 3 top. The operands used are opA[sel] and opB[sel]; the operands of the other neighbours have no effect.
- R5: When expressing, sum = a ^ b' ^ cin and carry = majority(a, b', cin), where b' is the operand b after the configuration step of R6.
- R6: Neighbour n's two-bit configuration word sits at GENOME[2n+1:2n]. Bit 2n high chains the carry in from upstream. Bit 2n+1 high inverts operand b. The default GENOME is 8'b01110001: left chains; down has no chain (cin = 0); right chains with b inverted; top chains.
- R7: For a chaining neighbour n, cin = upWc[n] when upMoved[n] is 0. Otherwise cin = upSpare[4n + w], where w = upWhere[2n+1:2n] names which spare of the upstream cell replaced it (same 0..3 direction code as R4). Spare outputs other than the one selected have no effect.
- R8: routeActive is one-hot at bit sel while expressing and all zero otherwise. Upstream inputs of a neighbour whose multiplexer is inactive have no effect.
- R9: For a neighbour whose chain bit is clear, cin is 0 regardless of every upstream input.
- R10: A load takes effect at the clock edge that samples it. Outputs keep the old configuration before that edge and show the new one immediately after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Strobe that captures cfgDiff and cfgDir |
| cfgDiff | input | 1 | Express flag to load |
| cfgDir | input | 2 | Neighbour selector to load (0 left, 1 down, 2 right, 3 top) |
| opA | input | 4 | Operand a of each neighbour, bit n for neighbour n |
| opB | input | 4 | Operand b of each neighbour |
| upWc | input | 4 | Carry from each neighbour's original upstream cell |
| upSpare | input | 16 | Carries from the four spares of each neighbour's upstream, bit 4n+s |
| upMoved | input | 4 | Upstream of neighbour n has been replaced |
| upWhere | input | 8 | Which spare replaced neighbour n's upstream, bits 2n+1:2n |
| sum | output | 1 | Full-adder sum of the expressed function |
| carry | output | 1 | Full-adder carry of the expressed function |
| outValid | output | 1 | High while expressing |
| routeActive | output | 4 | One-hot: which neighbour's input multiplexer is connected |

## Verification
The bench expresses each neighbour in turn and sweeps every operand value, every upstream repair state and every replacing-spare index. The spares that are not selected carry the opposite value, so a design that indexes the upstream spare vector wrongly gives a wrong carry. During the sweep the operands and upstream lines of the other three neighbours change at random. This catches a design that leaks a disconnected neighbour into the result, or that swaps the selector code order. The down neighbour, which has no chain, and the right neighbour, which inverts b, show whether the per-neighbour configuration word is decoded at the right bit positions. A design that lets configuration inputs through without the strobe, or that lags the strobe by a cycle, fails the checks made just before and just after the load edge.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int DIR_W = 2;
  localparam int NBR = 1 << DIR_W;
  localparam int GW = 2;

  typedef struct packed {
    logic express;
    logic [DIR_W-1:0] dir;
    logic [NBR-1:0] routeEn;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cfgLoad,
  input  logic cfgDiff,
  input  logic [DIR_W-1:0] cfgDir,
  output ctrl_t ctrl
);
  logic diffQ;
  logic [DIR_W-1:0] dirQ;
  logic [NBR-1:0] enVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      diffQ <= 1'b0;
      dirQ <= '0;
    end else if (cfgLoad) begin
      diffQ <= cfgDiff;
      dirQ <= cfgDir;
    end
  end

  genvar n;
  generate
    for (n = 0; n < NBR; n++) begin : g_en
      assign enVec[n] = diffQ && (dirQ == DIR_W'(n));
    end
  endgenerate

  always_comb begin
    ctrl.express = diffQ;
    ctrl.dir = dirQ;
    ctrl.routeEn = enVec;
  end
endmodule

// File: rtl/sc_route_mux.sv
module sc_route_mux
  import sc_pkg::*;
(
  input  logic en,
  input  logic chain,
  input  logic moved,
  input  logic [DIR_W-1:0] where,
  input  logic upWc,
  input  logic [NBR-1:0] upSpare,
  output logic routed
);
  always_comb begin
    routed = 1'b0;
    if (en && chain) begin
      if (moved) routed = upSpare[where];
      else routed = upWc;
    end
  end
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter logic [NBR*GW-1:0] GENOME = 8'b01110001
) (
  input  ctrl_t ctrl,
  input  logic [NBR-1:0] opA,
  input  logic [NBR-1:0] opB,
  input  logic [NBR-1:0] upWc,
  input  logic [NBR*NBR-1:0] upSpare,
  input  logic [NBR-1:0] upMoved,
  input  logic [NBR*DIR_W-1:0] upWhere,
  output logic sum,
  output logic carry,
  output logic outValid,
  output logic [NBR-1:0] routeActive
);
  logic [NBR-1:0] routedVec;
  logic [GW-1:0] gene;
  logic aSel, bSel, cinSel;

  genvar n;
  generate
    for (n = 0; n < NBR; n++) begin : g_mux
      sc_route_mux i_mux (
        .en(ctrl.routeEn[n]),
        .chain(GENOME[n*GW]),
        .moved(upMoved[n]),
        .where(upWhere[n*DIR_W +: DIR_W]),
        .upWc(upWc[n]),
        .upSpare(upSpare[n*NBR +: NBR]),
        .routed(routedVec[n])
      );
    end
  endgenerate

  always_comb begin
    gene = GENOME[ctrl.dir*GW +: GW];
    aSel = opA[ctrl.dir] & ctrl.express;
    bSel = (opB[ctrl.dir] ^ gene[1]) & ctrl.express;
    cinSel = |routedVec;
    sum = aSel ^ bSel ^ cinSel;
    carry = (aSel & bSel) | (aSel & cinSel) | (bSel & cinSel);
    outValid = ctrl.express;
    routeActive = ctrl.routeEn;
  end
endmodule

// File: rtl/spare_cell.sv
module spare_cell
  import sc_pkg::*;
#(
  parameter logic [NBR*GW-1:0] GENOME = 8'b01110001
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgLoad,
  input  logic cfgDiff,
  input  logic [DIR_W-1:0] cfgDir,
  input  logic [NBR-1:0] opA,
  input  logic [NBR-1:0] opB,
  input  logic [NBR-1:0] upWc,
  input  logic [NBR*NBR-1:0] upSpare,
  input  logic [NBR-1:0] upMoved,
  input  logic [NBR*DIR_W-1:0] upWhere,
  output logic sum,
  output logic carry,
  output logic outValid,
  output logic [NBR-1:0] routeActive
);
  ctrl_t ctrl;

  sc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .cfgDiff(cfgDiff), .cfgDir(cfgDir), .ctrl(ctrl)
  );

  sc_datapath #(.GENOME(GENOME)) i_dp (
    .ctrl(ctrl), .opA(opA), .opB(opB), .upWc(upWc), .upSpare(upSpare),
    .upMoved(upMoved), .upWhere(upWhere), .sum(sum), .carry(carry),
    .outValid(outValid), .routeActive(routeActive)
  );
endmodule

// File: rtl/sc_chk.sv
module sc_chk
  import sc_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic cfgLoad,
  input logic cfgDiff,
  input logic sum,
  input logic carry,
  input logic outValid,
  input logic [NBR-1:0] routeActive
);
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!sum && !carry));

  // R3
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cfgLoad)) |-> ($stable(outValid) && $stable(routeActive)));

  // R10
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgLoad) && $past(rstN)) |-> (outValid == $past(cfgDiff)));

  // R8
  one_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(routeActive));

  // R8
  route_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == (routeActive != '0));
endmodule

bind spare_cell sc_chk i_chk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgDiff(cfgDiff),
  .sum(sum), .carry(carry), .outValid(outValid), .routeActive(routeActive)
);

// File: tb/test_spare_cell.sv
module test_spare_cell;
  localparam int PER = 10;
  localparam logic [7:0] GEN = 8'b01110001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic cfgDiff = 1'b0;
  logic [1:0] cfgDir = 2'd0;
  logic [3:0] opA = '0, opB = '0, upWc = '0, upMoved = '0;
  logic [15:0] upSpare = '0;
  logic [7:0] upWhere = '0;
  logic sum, carry, outValid;
  logic [3:0] routeActive;
  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  spare_cell i_spare_cell (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgDiff(cfgDiff),
    .cfgDir(cfgDir), .opA(opA), .opB(opB), .upWc(upWc), .upSpare(upSpare),
    .upMoved(upMoved), .upWhere(upWhere), .sum(sum), .carry(carry),
    .outValid(outValid), .routeActive(routeActive)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {1'b0, outValid, sum, carry, routeActive};
  endfunction

  task automatic load(input logic d, input logic [1:0] s);
    @(negedge clk);
    cfgLoad = 1'b1; cfgDiff = d; cfgDir = s;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic noise();
    opA = 4'($urandom); opB = 4'($urandom); upWc = 4'($urandom);
    upSpare = 16'($urandom); upMoved = 4'($urandom); upWhere = 8'($urandom);
  endtask

  initial begin
    #(PER*100000);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    noise();
    #1;
    check("R1", outs(), 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", outs(), 8'h00);

    // R2: idle with random inputs
    for (int i = 0; i < 32; i++) begin
      noise();
      #1;
      check("R2", outs(), 8'h00);
    end

    // R3: config inputs change without strobe
    @(negedge clk);
    cfgDiff = 1'b1; cfgDir = 2'd2;
    repeat (3) @(negedge clk);
    check("R3", {7'd0, outValid}, 8'd0);
    check("R3", {4'd0, routeActive}, 8'd0);

    // R10: before and after the load edge
    @(negedge clk);
    cfgLoad = 1'b1; cfgDiff = 1'b1; cfgDir = 2'd2;
    #1;
    check("R10", {7'd0, outValid}, 8'd0);
    @(posedge clk);
    #1;
    cfgLoad = 1'b0;
    check("R10", {3'd0, outValid, routeActive}, 8'b0001_0100);
    @(negedge clk);
    cfgDir = 2'd0; cfgDiff = 1'b0;
    repeat (2) @(negedge clk);
    check("R3", {4'd0, routeActive}, 8'b0000_0100);

    // sweep each expressed neighbour
    for (int d = 0; d < 4; d++) begin
      load(1'b1, 2'(d));
      for (int v = 0; v < 128; v++) begin
        logic a, b, w, mv, sv, chain, inv, cinE, bb, s, c;
        logic [1:0] wh;
        string tag;
        a = v[0]; b = v[1]; w = v[2]; mv = v[3]; wh = v[5:4]; sv = v[6];
        @(negedge clk);
        noise();
        opA[d] = a; opB[d] = b; upWc[d] = w; upMoved[d] = mv;
        upWhere[d*2 +: 2] = wh;
        for (int k = 0; k < 4; k++) upSpare[d*4+k] = (k == wh) ? sv : ~sv;
        chain = GEN[2*d]; inv = GEN[2*d+1];
        cinE = chain ? (mv ? sv : w) : 1'b0;
        bb = b ^ inv;
        s = a ^ bb ^ cinE;
        c = (a & bb) | (a & cinE) | (bb & cinE);
        if (!chain) tag = "R9";
        else if (mv) tag = "R7";
        else if (inv) tag = "R6";
        else if (d == 0) tag = "R4";
        else tag = "R5";
        #1;
        check(tag, {5'd0, outValid, sum, carry}, {5'd0, 1'b1, s, c});
        check("R8", {4'd0, routeActive}, {4'd0, 4'b0001 << d});
      end
    end

    // back to idle
    load(1'b0, 2'd1);
    for (int i = 0; i < 8; i++) begin
      noise();
      #1;
      check("R2", outs(), 8'h00);
      @(negedge clk);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule